// File: doc/BRIEF.md
# Programmable Clock Output Channel

This block is one output lane of a clock fan-out tree. Every lane runs on the same fast source clock. A 2-bit path selector picks one of four routes for the lane's output. The direct route passes the source rate through. The divided route runs an even-ratio divider. The delayed route adds a whole-cycle delay. The fourth route uses the divider and then the delay. A per-lane enable gates the result to a steady low.

The output is modelled as a registered square wave in the source clock domain. The direct route is shown as a level that flips on every source edge. The divided route flips once every N source edges, where N is the 8-bit ratio field. This gives a full period of 2·N source cycles. The delay is a number of whole source cycles set by a 4-bit code.

A sync input is active low and shared by all lanes. While it is held low, every lane's counter stays cleared and its output stays low. All lanes restart together on the first edge after it is released, so their output edges line up. The ratio, delay and path fields are loaded into working registers only while sync is low, so a lane's phase never changes in the middle of a count.

Top module: `clkchan_out`

## Requirements
- R1: After reset, `clk_out` and `cfg_err` are low. The working settings after reset are direct path, ratio field 1 and delay code 0, and the output gate is closed.
- R2: The path code is 0 for direct, 1 for divided, 2 for delayed and 3 for divided-then-delayed. In path 0 the output flips on every source edge, and neither the ratio field nor the delay code has any effect.
- R3: In paths 1 and 3, the divided level flips once every F source edges, where F is the loaded ratio field. This gives a 50% duty square wave with a period of 2·F source cycles, for F from 1 to 255.
- R4: A ratio field of 0 loaded during sync is used as 1. It also sets `cfg_err`, which stays high until reset.
- R5: In path 2 the direct-rate level is delayed by exactly K source cycles, where K is the loaded 4-bit code (0 to 15). The ratio field has no effect in this path.
- R6: In path 3 the divided level is delayed by exactly K source cycles.
- R7: While `sync_n` is low, the divider count is zero and the output is low. The first output rise comes F+K source edges after the first edge with `sync_n` high, where F is 1 in paths 0 and 2 and K is 0 in paths 0 and 1.
- R8: Path, ratio and delay inputs are loaded only on edges where `sync_n` is low. Changes to them while `sync_n` is high leave the output unchanged.
- R9: With the gate closed, `clk_out` is low. `cfg_en` opens or closes the gate only on an edge where the gated level is low, so no shortened high pulse can appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Common high-rate source clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| sync_n | input | 1 | Active-low shared restart and configuration load |
| cfg_mode | input | 2 | Path selector: 0 direct, 1 divided, 2 delayed, 3 divided then delayed |
| cfg_div | input | DIV_W (8) | Ratio field; the divide ratio is twice this value |
| cfg_dly | input | DLY_W (4) | Delay code, in whole source cycles |
| cfg_en | input | 1 | Lane enable |
| clk_out | output | 1 | Gated lane output |
| cfg_err | output | 1 | Sticky flag for a ratio field of 0 |

## Verification
If the divider count holds a wrong value, the toggle spacing at `clk_out` goes wrong at the very next flip, and a per-cycle comparison catches that flip. A wrong delay tap or a wrong path selection moves every edge after the next sync. This shows within one output period, and after that edge it shows on every cycle. A gate that switches while the level is high cuts one pulse short in that same cycle. A working setting that follows the inputs without waiting for sync changes the period within one count, while the model still expects the old period.

// File: rtl/clkchan_pkg.sv
package clkchan_pkg;

   typedef enum logic [1:0] {
      PATH_DIRECT = 2'd0,
      PATH_DIV    = 2'd1,
      PATH_DLY    = 2'd2,
      PATH_DIVDLY = 2'd3
   } path_e;

   function automatic logic path_has_div(path_e p);
      return (p == PATH_DIV) || (p == PATH_DIVDLY);
   endfunction

   function automatic logic path_has_dly(path_e p);
      return (p == PATH_DLY) || (p == PATH_DIVDLY);
   endfunction

endpackage

// File: rtl/clkchan_cfg.sv
module clkchan_cfg
   import clkchan_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_n,
   input  logic [1:0]       mode_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic [DIV_W-1:0] lim_o,
   output logic [DLY_W-1:0] sel_o,
   output logic             err_o
);
   localparam logic [DIV_W-1:0] RATIO_ONE = DIV_W'(1);
   localparam logic [DLY_W-1:0] DLY_ZERO  = '0;

   path_e            path_q;
   logic [DIV_W-1:0] ratio_q;
   logic [DLY_W-1:0] dly_q;
   logic             err_q;
   logic             zero_field;

   assign zero_field = (div_i == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         path_q  <= PATH_DIRECT;
         ratio_q <= RATIO_ONE;
         dly_q   <= DLY_ZERO;
         err_q   <= 1'b0;
      end else if (!sync_n) begin
         path_q  <= path_e'(mode_i);
         ratio_q <= zero_field ? RATIO_ONE : div_i;
         dly_q   <= dly_i;
         err_q   <= err_q | zero_field;
      end
   end

   always_comb begin
      lim_o = path_has_div(path_q) ? ratio_q : RATIO_ONE;
      sel_o = path_has_dly(path_q) ? dly_q : DLY_ZERO;
   end

   assign err_o = err_q;

   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sync_n |=> ($stable(path_q) && $stable(ratio_q) && $stable(dly_q)));

   p_lim_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lim_o != '0);

endmodule

// File: rtl/clkchan_div.sv
module clkchan_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_n,
   input  logic [DIV_W-1:0] lim_i,
   output logic             q_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             lvl_q;
   logic             wrap;

   assign wrap = (cnt_q == (lim_i - DIV_W'(1)));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (!sync_n) begin
         cnt_q <= '0;
         lvl_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         lvl_q <= ~lvl_q;
      end else begin
         cnt_q <= cnt_q + DIV_W'(1);
      end
   end

   assign q_o = lvl_q;

   p_sync_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_n |=> (q_o == 1'b0 && cnt_q == '0));

   p_fast_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_n && lim_i == DIV_W'(1)) |=> (q_o != $past(q_o)));

   p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < lim_i);

endmodule

// File: rtl/clkchan_dly.sv
module clkchan_dly #(
   parameter int DLY_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             d_i,
   input  logic [DLY_W-1:0] sel_i,
   output logic             q_o
);
   localparam int DEPTH = (1 << DLY_W) - 1;

   logic [DEPTH:1] stg_q;
   logic [DEPTH:0] taps;

   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) stg_q <= '0;
            else        stg_q <= {stg_q[DEPTH-1:1], d_i};
         end
      end
   endgenerate

   assign taps = {stg_q, d_i};
   assign q_o  = taps[sel_i];

   p_first_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(d_i) |=> stg_q[1]);

endmodule

// File: rtl/clkchan_gate.sv
module clkchan_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic d_i,
   output logic q_o
);
   logic open_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    open_q <= 1'b0;
      else if (!d_i) open_q <= en_i;
   end

   assign q_o = open_q & d_i;

   p_gate_at_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(open_q) |-> !$past(d_i));

   p_closed_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !open_q |-> !q_o);

endmodule

// File: rtl/clkchan_out.sv
module clkchan_out #(
   parameter int DIV_W = 8,
   parameter int DLY_W = 4
) (
   input  logic             src_clk,
   input  logic             rst_n,
   input  logic             sync_n,
   input  logic [1:0]       cfg_mode,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic [DLY_W-1:0] cfg_dly,
   input  logic             cfg_en,
   output logic             clk_out,
   output logic             cfg_err
);
   generate
      if (DIV_W < 2 || DIV_W > 16) begin : g_bad_div
         $error("clkchan_out: DIV_W must lie in 2..16");
      end
      if (DLY_W < 1 || DLY_W > 8) begin : g_bad_dly
         $error("clkchan_out: DLY_W must lie in 1..8");
      end
   endgenerate

   logic [DIV_W-1:0] lim;
   logic [DLY_W-1:0] sel;
   logic             base_lvl;
   logic             dly_lvl;

   clkchan_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_cfg (
      .clk    (src_clk),
      .rst_n  (rst_n),
      .sync_n (sync_n),
      .mode_i (cfg_mode),
      .div_i  (cfg_div),
      .dly_i  (cfg_dly),
      .lim_o  (lim),
      .sel_o  (sel),
      .err_o  (cfg_err)
   );

   clkchan_div #(.DIV_W(DIV_W)) u_div (
      .clk    (src_clk),
      .rst_n  (rst_n),
      .sync_n (sync_n),
      .lim_i  (lim),
      .q_o    (base_lvl)
   );

   clkchan_dly #(.DLY_W(DLY_W)) u_dly (
      .clk    (src_clk),
      .rst_n  (rst_n),
      .d_i    (base_lvl),
      .sel_i  (sel),
      .q_o    (dly_lvl)
   );

   clkchan_gate u_gate (
      .clk    (src_clk),
      .rst_n  (rst_n),
      .en_i   (cfg_en),
      .d_i    (dly_lvl),
      .q_o    (clk_out)
   );

   p_sync_quiet_r7: assert property (@(posedge src_clk) disable iff (!rst_n)
      !sync_n |=> !base_lvl);

   p_undelayed_tap_r6: assert property (@(posedge src_clk) disable iff (!rst_n)
      (sel == '0) |-> (dly_lvl == base_lvl));

endmodule

// File: tb/clkchan_out_bench.sv
`timescale 1ns/1ps
module clkchan_out_bench;
   logic       src_clk = 1'b0;
   logic       rst_n;
   logic       sync_n;
   logic [1:0] cfg_mode;
   logic [7:0] cfg_div;
   logic [3:0] cfg_dly;
   logic       cfg_en;
   logic       clk_out;
   logic       cfg_err;

   int    n_checks = 0;
   int    n_fail   = 0;
   string tag      = "R1";

   always #2.5 src_clk = ~src_clk;

   clkchan_out u_clkchan_out (
      .src_clk  (src_clk),
      .rst_n    (rst_n),
      .sync_n   (sync_n),
      .cfg_mode (cfg_mode),
      .cfg_div  (cfg_div),
      .cfg_dly  (cfg_dly),
      .cfg_en   (cfg_en),
      .clk_out  (clk_out),
      .cfg_err  (cfg_err)
   );

   // behavioural reference: time since restart and a history of levels
   int m_t, m_mode, m_ratio, m_code, m_g, m_err;
   int hist [16];

   function automatic int tap_now();
      return (m_mode == 2 || m_mode == 3) ? m_code : 0;
   endfunction

   always @(posedge src_clk) begin
      int lvl, period_half, old_d;
      if (!rst_n) begin
         m_t = 0; m_mode = 0; m_ratio = 1; m_code = 0; m_g = 0; m_err = 0;
         for (int i = 0; i < 16; i++) hist[i] = 0;
      end else begin
         old_d = hist[tap_now()];
         if (old_d == 0) m_g = cfg_en;
         if (!sync_n) begin
            m_t = 0;
            if (cfg_div == 0) m_err = 1;
            m_mode  = cfg_mode;
            m_ratio = (cfg_div == 0) ? 1 : cfg_div;
            m_code  = cfg_dly;
            lvl = 0;
         end else begin
            m_t++;
            period_half = (m_mode == 1 || m_mode == 3) ? m_ratio : 1;
            lvl = (m_t / period_half) % 2;
         end
         for (int i = 15; i > 0; i--) hist[i] = hist[i-1];
         hist[0] = lvl;
      end
   end

   always @(negedge src_clk) begin
      int exp_o;
      exp_o = m_g & hist[tap_now()];
      n_checks++;
      if (clk_out !== exp_o[0] || cfg_err !== m_err[0]) begin
         n_fail++;
         $display("FAIL %s t=%0t clk_out=%b/exp %0d cfg_err=%b/exp %0d",
                  tag, $time, clk_out, exp_o, cfg_err, m_err);
      end
   end

   task automatic run(input int n, input string t);
      tag = t;
      repeat (n) @(negedge src_clk);
   endtask

   task automatic sync_pulse(input int n);
      sync_n = 1'b0;
      repeat (n) @(negedge src_clk);
      sync_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog expired in %s", tag);
      finish_run();
   end

   initial begin
      int first;
      rst_n = 1'b0; sync_n = 1'b1;
      cfg_mode = 2'd0; cfg_div = 8'd1; cfg_dly = 4'd0; cfg_en = 1'b0;
      run(4, "R1");
      rst_n = 1'b1;
      run(8, "R1");                          // R1: output low, flag low, gate closed

      cfg_en = 1'b1;
      run(12, "R9");                         // R9: gate opens on a low level
      cfg_mode = 2'd0; cfg_div = 8'd5; cfg_dly = 4'd7;
      sync_pulse(2);
      run(20, "R2");                         // R2: direct path ignores ratio and delay

      cfg_mode = 2'd1; cfg_div = 8'd3;
      sync_pulse(3);
      run(40, "R3");                         // R3: period 6
      cfg_div = 8'd7; cfg_mode = 2'd2;
      run(40, "R8");                         // R8: no load without sync

      cfg_div = 8'd255; cfg_mode = 2'd1;
      sync_pulse(1);
      run(1100, "R3");                       // R3: largest ratio, period 510

      cfg_mode = 2'd2; cfg_div = 8'd9;
      for (int k = 0; k < 16; k += 5) begin
         cfg_dly = 4'(k);
         sync_pulse(2);
         run(40, "R5");                      // R5: delays 0, 5, 10, 15
      end

      cfg_mode = 2'd3; cfg_div = 8'd4; cfg_dly = 4'd5;
      sync_pulse(4);
      run(60, "R6");                         // R6: divided then delayed

      cfg_mode = 2'd3; cfg_div = 8'd4; cfg_dly = 4'd5;
      sync_n = 1'b0;
      run(10, "R7");                         // R7: held low while sync is low
      sync_n = 1'b1;
      first = 0;
      for (int k = 1; k <= 20; k++) begin
         @(negedge src_clk);
         if (first == 0 && clk_out) first = k;
      end
      n_checks++;
      if (first != 9) begin
         n_fail++;
         $display("FAIL R7 first rise after %0d edges, expected 9", first);
      end

      cfg_mode = 2'd1; cfg_div = 8'd0;
      sync_pulse(2);
      run(30, "R4");                         // R4: zero field behaves as 1, flag set
      cfg_div = 8'd2;
      sync_pulse(2);
      run(30, "R4");                         // R4: flag stays set

      cfg_div = 8'd6;
      sync_pulse(1);
      run(9, "R9");
      cfg_en = 1'b0;                         // mid high phase: the pulse must finish
      run(30, "R9");
      cfg_en = 1'b1;
      run(30, "R9");

      finish_run();
   end
endmodule